// File: doc/BRIEF.md
# Low-Power Event Counter with Delayed Reload and Compare Registers

This block is a small counter and timer that software controls over a simple synchronous register bus. It holds a ceiling (reload) value, a compare value, a configuration word and a control word. The count source is chosen by the configuration word. In encoder mode the block takes up and down strobes from an external edge decoder. In external-count mode it counts only the up strobe. Otherwise it counts internal clock ticks, divided down by a power-of-two prescaler. The count wraps at the ceiling in both directions.

Writes to the ceiling and compare registers are accepted only while the timer is enabled. Each accepted value waits in a shadow register for a fixed number of cycles before it lands. Its landing is reported by a status flag, and the flag is cleared by writing ones to a separate clear address. Counting begins only when a start command is written together with the enable bit. The polarity and encoder settings are driven out to the edge decoder that feeds the strobes.

Top module: `lpt_core`

## Requirements
- R1: After reset the count, compare, status, control and configuration registers read 0, the ceiling reads 0xFFFF, and edge_pol and enc_on are 0.
- R2: A bus write to the ceiling (address 5) or compare (address 4) register while the enable bit is 0 is dropped: the register keeps its value and no status flag is set.
- R3: A write to the ceiling or compare register while enabled lands exactly 3 clock edges after the write edge. On that same edge the ceiling-done flag (status bit 2) or compare-done flag (status bit 1) is set. A second write before landing restarts the delay with the newer value.
- R4: Writing to the clear address (1) clears each status bit whose data bit is 1 and leaves the other status bits unchanged.
- R5: The count moves only while running. A control write (address 3) with bit 0 (enable) and bit 1 (start) both set starts running, and enable alone does not. Control bits read back as {running, enable} in bits [1:0].
- R6: Writing zero to the control register clears enable and running. The count then holds its value.
- R7: The configuration register (address 2) is written only while enable is 0, and writes made while enabled are ignored. Its fields are encoder-mode at bit 0, external-count at bit 1, edge polarity at [3:2] (0 rising, 1 falling, 2 both) and prescaler exponent at [6:4].
- R8: In encoder mode an up strobe adds 1, a down strobe subtracts 1, and both strobes together leave the count unchanged.
- R9: In external-count mode with encoder mode off, an up strobe adds 1 and a down strobe is ignored.
- R10: With both mode bits 0 the count adds 1 every 2^P clock edges while running, where P is the prescaler exponent.
- R11: Counting up from a value at or above the ceiling gives 0, and counting down from 0 gives the ceiling.
- R12: Status bit 0 (match) is set on the edge where the count takes a new value equal to the compare register.
- R13: Output edge_pol carries the polarity field and output enc_on carries the encoder-mode bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; data is valid after the next edge |
| bus_addr | input | 3 | Register address (0 status, 1 clear, 2 config, 3 control, 4 compare, 5 ceiling, 6 count) |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| up_stb | input | 1 | Up-count strobe from the edge decoder |
| dn_stb | input | 1 | Down-count strobe from the edge decoder |
| edge_pol | output | 2 | Polarity selection for the edge decoder |
| enc_on | output | 1 | Encoder mode enabled, for the edge decoder |

## Verification
The count engine is tested with single up strobes, single down strobes, simultaneous up and down strobes, and free-running clock ticks. Running the same strobe pattern in encoder mode and in external-count mode shows whether down strobes are honoured or discarded. Stepping across the ceiling in both directions shows whether the wrap uses the live ceiling value. Reading status on each edge after a ceiling write shows the exact landing cycle, so a delay that is one cycle too short or too long is caught.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_STAT = 3'd0;
  localparam logic [AW-1:0] A_CLR  = 3'd1;
  localparam logic [AW-1:0] A_CFG  = 3'd2;
  localparam logic [AW-1:0] A_CTRL = 3'd3;
  localparam logic [AW-1:0] A_CMP  = 3'd4;
  localparam logic [AW-1:0] A_RLD  = 3'd5;
  localparam logic [AW-1:0] A_CNT  = 3'd6;

  // status bit positions (also used by the clear address)
  localparam int ST_MATCH = 0;
  localparam int ST_CMPOK = 1;
  localparam int ST_RLDOK = 2;
  localparam int NST      = 3;

  // control bit positions
  localparam int CTL_EN = 0;
  localparam int CTL_GO = 1;

  // shadow channel indices
  localparam int CH_CMP = 0;
  localparam int CH_RLD = 1;
  localparam int NCH    = 2;

  typedef struct packed {
    logic [2:0] presc;
    logic [1:0] pol;
    logic       ext;
    logic       enc;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/lpt_wrdelay.sv
module lpt_wrdelay #(
  parameter int           W       = 16,
  parameter int           LAT     = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_req,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cur_val,
  output logic         done
);
  localparam int TW = (LAT < 2) ? 1 : $clog2(LAT);

  logic [W-1:0]  shadow;
  logic [TW-1:0] tmr;
  logic          pend;

  assign done = pend && (tmr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= '0;
      tmr     <= '0;
      pend    <= 1'b0;
      cur_val <= RST_VAL;
    end else if (wr_req) begin
      shadow <= wr_val;
      tmr    <= TW'(LAT - 1);
      pend   <= 1'b1;
    end else if (pend) begin
      if (tmr == '0) begin
        cur_val <= shadow;
        pend    <= 1'b0;
      end else begin
        tmr <= tmr - 1'b1;
      end
    end
  end
endmodule

// File: rtl/lpt_count.sv
module lpt_count #(
  parameter int W     = 16,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             enc,
  input  logic             ext,
  input  logic [PSC_W-1:0] presc,
  input  logic             up_stb,
  input  logic             dn_stb,
  input  logic [W-1:0]     rld,
  input  logic [W-1:0]     cmp,
  output logic [W-1:0]     cnt,
  output logic             match
);
  localparam int DIVW = (1 << PSC_W) - 1;

  logic [DIVW-1:0] div;
  logic [DIVW-1:0] lim;
  logic            tick;
  logic            inc, dec, step;
  logic [W-1:0]    nxt;

  assign lim  = DIVW'((32'd1 << presc) - 32'd1);
  assign tick = (div == lim);

  always_ff @(posedge clk) begin
    if (rst || !run || enc || ext || tick) div <= '0;
    else                                   div <= div + 1'b1;
  end

  always_comb begin
    inc = 1'b0;
    dec = 1'b0;
    if (enc) begin
      inc = up_stb & ~dn_stb;
      dec = dn_stb & ~up_stb;
    end else if (ext) begin
      inc = up_stb;
    end else begin
      inc = tick;
    end
  end

  always_comb begin
    nxt = cnt;
    if (inc)      nxt = (cnt >= rld) ? '0 : cnt + 1'b1;
    else if (dec) nxt = (cnt == '0) ? rld : cnt - 1'b1;
  end

  assign step  = run & (inc | dec);
  assign match = step & (nxt == cmp);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= nxt;
  end
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic           re,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  cnt,
  input  logic [DW-1:0]  cmp,
  input  logic [DW-1:0]  rld,
  input  logic           cmp_done,
  input  logic           rld_done,
  input  logic           match,
  output logic           en,
  output logic           run,
  output cfg_t           cfg,
  output logic [NST-1:0] stat,
  output logic           wr_cmp,
  output logic           wr_rld,
  output logic [DW-1:0]  rdata
);
  logic [NST-1:0] set_v, clr_v;
  logic [DW-1:0]  rmux;

  assign wr_cmp = we && (addr == A_CMP) && en;
  assign wr_rld = we && (addr == A_RLD) && en;

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      run <= 1'b0;
    end else if (we && addr == A_CTRL) begin
      en  <= wdata[CTL_EN];
      run <= wdata[CTL_EN] & (wdata[CTL_GO] | run);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                             cfg <= '0;
    else if (we && addr == A_CFG && !en) cfg <= cfg_t'(wdata[CFG_W-1:0]);
  end

  always_comb begin
    set_v           = '0;
    set_v[ST_MATCH] = match;
    set_v[ST_CMPOK] = cmp_done;
    set_v[ST_RLDOK] = rld_done;
    clr_v = (we && addr == A_CLR) ? wdata[NST-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (stat & ~clr_v) | set_v;
  end

  always_comb begin
    case (addr)
      A_STAT:  rmux = DW'(stat);
      A_CFG:   rmux = DW'(cfg);
      A_CTRL:  rmux = DW'({run, en});
      A_CMP:   rmux = cmp;
      A_RLD:   rmux = rld;
      A_CNT:   rmux = cnt;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rmux;
  end
endmodule

// File: rtl/lpt_core.sv
module lpt_core
  import lpt_pkg::*;
#(
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] RLD_MAX = '1,
  parameter int               WR_LAT  = 3,
  parameter int               PSC_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             up_stb,
  input  logic             dn_stb,
  output logic [1:0]       edge_pol,
  output logic             enc_on
);
  logic             en_w, run_w;
  cfg_t             cfg_w;
  logic [NST-1:0]   stat_w;
  logic [CNT_W-1:0] cnt_w;
  logic             match_w;
  logic [NCH-1:0]   wreq, wdone;
  logic [CNT_W-1:0] wval [NCH];
  logic [CNT_W-1:0] cur  [NCH];
  logic [CNT_W-1:0] cmp_w, rld_w;

  assign wval[CH_CMP] = bus_wdata;
  assign wval[CH_RLD] = (bus_wdata > RLD_MAX) ? RLD_MAX : bus_wdata;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [CNT_W-1:0] RV = (g == CH_RLD) ? RLD_MAX : '0;
    lpt_wrdelay #(.W(CNT_W), .LAT(WR_LAT), .RST_VAL(RV)) u_dly (
      .clk    (clk),
      .rst    (rst),
      .wr_req (wreq[g]),
      .wr_val (wval[g]),
      .cur_val(cur[g]),
      .done   (wdone[g])
    );
  end

  assign cmp_w = cur[CH_CMP];
  assign rld_w = cur[CH_RLD];

  lpt_regs #(.DW(CNT_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (bus_we),
    .re      (bus_re),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .cnt     (cnt_w),
    .cmp     (cmp_w),
    .rld     (rld_w),
    .cmp_done(wdone[CH_CMP]),
    .rld_done(wdone[CH_RLD]),
    .match   (match_w),
    .en      (en_w),
    .run     (run_w),
    .cfg     (cfg_w),
    .stat    (stat_w),
    .wr_cmp  (wreq[CH_CMP]),
    .wr_rld  (wreq[CH_RLD]),
    .rdata   (bus_rdata)
  );

  lpt_count #(.W(CNT_W), .PSC_W(PSC_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (run_w),
    .enc   (cfg_w.enc),
    .ext   (cfg_w.ext),
    .presc (PSC_W'(cfg_w.presc)),
    .up_stb(up_stb),
    .dn_stb(dn_stb),
    .rld   (rld_w),
    .cmp   (cmp_w),
    .cnt   (cnt_w),
    .match (match_w)
  );

  assign edge_pol = cfg_w.pol;
  assign enc_on   = cfg_w.enc;
endmodule

// File: rtl/lpt_core_chk.sv
module lpt_core_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             up_stb,
  input logic             dn_stb,
  input logic             en,
  input logic             run,
  input logic             enc,
  input logic             ext,
  input logic [6:0]       cfg,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rld
);
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));                                         // R6
  AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    run |-> en);                                                    // R5
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    en |=> $stable(cfg));                                           // R7
  AST_ENC_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run && enc && up_stb && dn_stb) |=> $stable(cnt));             // R8
  AST_EXT_DN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (run && !enc && ext && dn_stb && !up_stb) |=> $stable(cnt));    // R9
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (run && enc && up_stb && !dn_stb && cnt == rld) |=> (cnt == '0)); // R11
  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (run && enc && dn_stb && !up_stb && cnt == '0) |=> (cnt == $past(rld))); // R11
endmodule

bind lpt_core lpt_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .up_stb(up_stb),
  .dn_stb(dn_stb),
  .en    (en_w),
  .run   (run_w),
  .enc   (cfg_w.enc),
  .ext   (cfg_w.ext),
  .cfg   (cfg_w),
  .cnt   (cnt_w),
  .rld   (rld_w)
);

// File: tb/lpt_core_tb_top.sv
module lpt_core_tb_top;
  localparam logic [2:0] OP_W = 3'd0;
  localparam logic [2:0] OP_R = 3'd1;
  localparam logic [2:0] OP_I = 3'd2;
  localparam logic [2:0] OP_U = 3'd3;
  localparam logic [2:0] OP_D = 3'd4;
  localparam logic [2:0] OP_B = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 64;
  localparam vec_t TBL [NV] = '{
    '{OP_R, 3'd0, 16'h0000, 16'h0000, 4'd1},   // R1 status
    '{OP_R, 3'd5, 16'h0000, 16'hFFFF, 4'd1},   // R1 ceiling
    '{OP_R, 3'd4, 16'h0000, 16'h0000, 4'd1},   // R1 compare
    '{OP_R, 3'd6, 16'h0000, 16'h0000, 4'd1},   // R1 count
    '{OP_R, 3'd3, 16'h0000, 16'h0000, 4'd1},   // R1 control
    '{OP_W, 3'd5, 16'h0005, 16'h0000, 4'd0},
    '{OP_W, 3'd4, 16'h0007, 16'h0000, 4'd0},
    '{OP_I, 3'd0, 16'd4,    16'h0000, 4'd0},
    '{OP_R, 3'd5, 16'h0000, 16'hFFFF, 4'd2},   // R2
    '{OP_R, 3'd4, 16'h0000, 16'h0000, 4'd2},   // R2
    '{OP_R, 3'd0, 16'h0000, 16'h0000, 4'd2},   // R2
    '{OP_W, 3'd2, 16'h0009, 16'h0000, 4'd0},
    '{OP_R, 3'd2, 16'h0000, 16'h0009, 4'd7},   // R7 accepted while off
    '{OP_W, 3'd3, 16'h0001, 16'h0000, 4'd0},
    '{OP_W, 3'd5, 16'h0005, 16'h0000, 4'd0},
    '{OP_R, 3'd5, 16'h0000, 16'hFFFF, 4'd3},   // R3 edge +1
    '{OP_R, 3'd0, 16'h0000, 16'h0000, 4'd3},   // R3 edge +2
    '{OP_R, 3'd0, 16'h0000, 16'h0000, 4'd3},   // R3 edge +3 (pre-edge)
    '{OP_R, 3'd0, 16'h0000, 16'h0004, 4'd3},   // R3 landed
    '{OP_R, 3'd5, 16'h0000, 16'h0005, 4'd3},   // R3
    '{OP_W, 3'd2, 16'h0000, 16'h0000, 4'd0},
    '{OP_R, 3'd2, 16'h0000, 16'h0009, 4'd7},   // R7 locked while on
    '{OP_W, 3'd4, 16'h0003, 16'h0000, 4'd0},
    '{OP_I, 3'd0, 16'd3,    16'h0000, 4'd0},
    '{OP_R, 3'd0, 16'h0000, 16'h0006, 4'd3},   // R3 both done flags
    '{OP_R, 3'd4, 16'h0000, 16'h0003, 4'd3},   // R3
    '{OP_W, 3'd1, 16'h0002, 16'h0000, 4'd0},
    '{OP_R, 3'd0, 16'h0000, 16'h0004, 4'd4},   // R4 partial clear
    '{OP_W, 3'd1, 16'h0004, 16'h0000, 4'd0},
    '{OP_R, 3'd0, 16'h0000, 16'h0000, 4'd4},   // R4
    '{OP_U, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_R, 3'd6, 16'h0000, 16'h0000, 4'd5},   // R5 enabled, not started
    '{OP_W, 3'd3, 16'h0003, 16'h0000, 4'd0},
    '{OP_U, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_U, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_R, 3'd6, 16'h0000, 16'h0002, 4'd8},   // R8 up
    '{OP_D, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_R, 3'd6, 16'h0000, 16'h0001, 4'd8},   // R8 down
    '{OP_B, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_R, 3'd6, 16'h0000, 16'h0001, 4'd8},   // R8 both
    '{OP_U, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_U, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_R, 3'd0, 16'h0000, 16'h0001, 4'd12},  // R12 match
    '{OP_W, 3'd1, 16'h0001, 16'h0000, 4'd0},
    '{OP_R, 3'd0, 16'h0000, 16'h0000, 4'd4},   // R4 match cleared
    '{OP_U, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_U, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_U, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_R, 3'd6, 16'h0000, 16'h0000, 4'd11},  // R11 up wrap
    '{OP_D, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_R, 3'd6, 16'h0000, 16'h0005, 4'd11},  // R11 down wrap
    '{OP_W, 3'd3, 16'h0000, 16'h0000, 4'd0},
    '{OP_U, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_R, 3'd6, 16'h0000, 16'h0005, 4'd6},   // R6 held
    '{OP_R, 3'd3, 16'h0000, 16'h0000, 4'd6},   // R6
    '{OP_W, 3'd2, 16'h0002, 16'h0000, 4'd0},
    '{OP_R, 3'd2, 16'h0000, 16'h0002, 4'd7},   // R7
    '{OP_W, 3'd3, 16'h0003, 16'h0000, 4'd0},
    '{OP_U, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_D, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_R, 3'd6, 16'h0000, 16'h0000, 4'd9},   // R9 down ignored
    '{OP_U, 3'd0, 16'h0000, 16'h0000, 4'd0},
    '{OP_R, 3'd6, 16'h0000, 16'h0001, 4'd9},   // R9
    '{OP_W, 3'd3, 16'h0000, 16'h0000, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        up_stb = 1'b0, dn_stb = 1'b0;
  logic [1:0]  edge_pol;
  logic        enc_on;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lpt_core dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .up_stb(up_stb), .dn_stb(dn_stb), .edge_pol(edge_pol), .enc_on(enc_on)
  );

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic strobe(input logic u, input logic dn);
    up_stb = u; dn_stb = dn;
    @(negedge clk);
    up_stb = 1'b0; dn_stb = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R0 actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        OP_W: wr(TBL[i].addr, TBL[i].data);
        OP_R: begin
          rd(TBL[i].addr, v);
          check(int'(TBL[i].req), v, TBL[i].exp);
        end
        OP_I: repeat (int'(TBL[i].data)) @(negedge clk);
        OP_U: strobe(1'b1, 1'b0);
        OP_D: strobe(1'b0, 1'b1);
        OP_B: strobe(1'b1, 1'b1);
        default: ;
      endcase
    end

    // R10: internal ticks, prescaler exponent 0 -> one step per edge
    do_reset();
    wr(3'd3, 16'h0003);
    repeat (5) @(negedge clk);
    wr(3'd3, 16'h0000);
    rd(3'd6, v);
    check(10, v, 16'd6);

    // R10: prescaler exponent 2 -> one step per 4 edges over 16 edges
    do_reset();
    wr(3'd2, 16'h0020);
    wr(3'd3, 16'h0003);
    repeat (15) @(negedge clk);
    wr(3'd3, 16'h0000);
    rd(3'd6, v);
    check(10, v, 16'd4);

    // R5: enable without start, internal ticks must not count
    do_reset();
    wr(3'd3, 16'h0001);
    repeat (5) @(negedge clk);
    rd(3'd6, v);
    check(5, v, 16'd0);
    rd(3'd3, v);
    check(5, v, 16'h0001);

    // R13 and R1: decoder-facing outputs
    do_reset();
    check(1, {14'd0, edge_pol}, 16'd0);
    check(1, {15'd0, enc_on}, 16'd0);
    wr(3'd2, 16'h0009);
    check(13, {14'd0, edge_pol}, 16'd2);
    check(13, {15'd0, enc_on}, 16'd1);
    wr(3'd2, 16'h0004);
    check(13, {14'd0, edge_pol}, 16'd1);
    check(13, {15'd0, enc_on}, 16'd0);

    // R3: a second write before landing restarts the delay
    wr(3'd3, 16'h0001);
    wr(3'd5, 16'h0009);
    wr(3'd5, 16'h0007);
    repeat (2) @(negedge clk);
    rd(3'd0, v);
    check(3, v, 16'h0000);
    rd(3'd5, v);
    check(3, v, 16'h0007);
    rd(3'd0, v);
    check(3, v, 16'h0004);

    // R1: reset in the middle of operation
    do_reset();
    rd(3'd5, v);
    check(1, v, 16'hFFFF);
    rd(3'd0, v);
    check(1, v, 16'h0000);
    rd(3'd2, v);
    check(1, v, 16'h0000);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule